// File: doc/BRIEF.md
# Shift-Add Three-Tap FIR Filter

This block is a three-tap FIR filter whose coefficients are fixed at 5, 13 and 5. It contains no multipliers. Each product is built from shifts and adders, and partial terms are shared between taps. A stream of signed samples enters with a valid strobe. For each accepted sample, one full-precision signed output is produced one cycle later.

Two factorings of the same transfer function are available, chosen at compile time by the `FORM` parameter:

- `FORM = 0`: the two outer taps are pre-added, because the coefficients are symmetric. The times-five term is formed once as `s + (s<<2)`. The centre product 13x is formed as the shared 5x of the middle sample plus that sample shifted left by three.
- `FORM = 1`: the sum of the newest and middle samples is formed first as `p = x[n] + x[n-1]`. The output is then `5p + 8x[n-1] + 5x[n-2]`.

Both variants give bit-identical outputs.

The delay line advances only on accepted samples. Idle cycles therefore never disturb the filter history.

Top module: `shiftadd_fir3`

## Requirements
- R1: While `rst_n` is low, and after its release, `out_valid` and `out_data` are 0 and the sample history is cleared. The first output after reset is therefore 5 times the first sample.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low in every other cycle.
- R3: For the n-th accepted sample, `out_data` equals 5·x[n] + 13·x[n-1] + 5·x[n-2]. Here x[k] are accepted samples in two's complement and missing history counts as 0.
- R4: A cycle with `in_valid` low does not change the history, whatever `in_data` holds during that cycle.
- R5: `out_data` keeps its value in every cycle that follows a cycle with `in_valid` low.
- R6: The result is never truncated. An all -128 history gives -2944 and an all 127 history gives 2921, both exactly representable in the 13-bit output.
- R7: `FORM = 0` (shared sub-expression with symmetric pre-add) and `FORM = 1` (newest-plus-middle pre-sum) produce identical `out_data` for every input sequence.

Output width is `IN_W + 5` bits, since the coefficient gain is 23 < 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe; `in_data` is accepted when high |
| in_data | input | IN_W (8) | Signed two's complement input sample |
| out_valid | output | 1 | High for one cycle per accepted sample |
| out_data | output | IN_W+5 (13) | Signed filter result |

## Verification
Every result is due exactly one clock edge after the sample that produced it. The history moves on that same edge, so the filter output of sample n already includes x[n-1] and x[n-2]. The bench drives each sample half a period before a rising edge and samples the outputs half a period after that edge. This places every check in the cycle that R2 requires, away from the edge itself. During idle cycles the bench checks one cycle after each low strobe that `out_valid` is low and `out_data` is unchanged. Both `FORM` variants run in parallel against the same reference convolution.

// File: rtl/fir_sa_pkg.sv
package fir_sa_pkg;
   // Sum of the fixed coefficients 5 + 13 + 5.
   localparam int COEF_GAIN = 23;
   // Extra bits needed so that COEF_GAIN * 2^(w-1) fits in a signed word.
   localparam int GROWTH_BITS = $clog2(COEF_GAIN);

   typedef enum int {
      FORM_SHARED   = 0,
      FORM_PRESUM   = 1
   } fir_form_e;

   function automatic int out_width(input int in_w);
      return in_w + GROWTH_BITS;
   endfunction
endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      shift,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   taps
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("fir_tap_line: DEPTH must be at least 1");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)
            taps[i] <= '0;
         else if (shift)
            taps[i] <= (i == 0) ? din : taps[(i == 0) ? 0 : i-1];
      end
   end

   // R4: history holds when no sample is accepted
   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(taps));
   // R4: newest sample enters stage 0 on an accepted sample
   a_r4_load_newest: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> taps[0] == $past(din));
endmodule

// File: rtl/fir_form_shared.sv
// Symmetric pre-add of the outer taps, one shared times-five term for the
// outer pair, a times-five term of the middle sample reused to make 13x.
module fir_form_shared #(
   parameter int IN_W = 8,
   parameter int OW   = 13
) (
   input  logic signed [IN_W-1:0] x0,
   input  logic signed [IN_W-1:0] x1,
   input  logic signed [IN_W-1:0] x2,
   output logic signed [OW-1:0]   y
);
   localparam int MAXV = fir_sa_pkg::COEF_GAIN * (2 ** (IN_W-1));

   logic signed [OW-1:0] e0, e1, e2;
   logic signed [OW-1:0] outer_sum, outer_x5, mid_x5, mid_x13;

   assign e0 = OW'(x0);
   assign e1 = OW'(x1);
   assign e2 = OW'(x2);

   assign outer_sum = e0 + e2;                       // h0 == h2
   assign outer_x5  = outer_sum + (outer_sum <<< 2); // 101b
   assign mid_x5    = e1 + (e1 <<< 2);               // shared 101b term
   assign mid_x13   = mid_x5 + (e1 <<< 3);           // 1101b = 101b + 1000b
   assign y         = outer_x5 + mid_x13;

   // R6: the sum stays inside the representable gain range
   always_comb begin
      a_r6_in_range: assert (y <= MAXV && y >= -MAXV);
   end
endmodule

// File: rtl/fir_form_presum.sv
// Factored form: p = x[n] + x[n-1]; y = 5p + 8x[n-1] + 5x[n-2].
module fir_form_presum #(
   parameter int IN_W = 8,
   parameter int OW   = 13
) (
   input  logic signed [IN_W-1:0] x0,
   input  logic signed [IN_W-1:0] x1,
   input  logic signed [IN_W-1:0] x2,
   output logic signed [OW-1:0]   y
);
   localparam int MAXV = fir_sa_pkg::COEF_GAIN * (2 ** (IN_W-1));

   logic signed [OW-1:0] e0, e1, e2;
   logic signed [OW-1:0] p, p_x5, old_x5, mid_x8;

   assign e0 = OW'(x0);
   assign e1 = OW'(x1);
   assign e2 = OW'(x2);

   assign p      = e0 + e1;
   assign p_x5   = p + (p <<< 2);
   assign old_x5 = e2 + (e2 <<< 2);
   assign mid_x8 = e1 <<< 3;
   assign y      = p_x5 + mid_x8 + old_x5;

   // R6: the sum stays inside the representable gain range
   always_comb begin
      a_r6_in_range: assert (y <= MAXV && y >= -MAXV);
   end
endmodule

// File: rtl/shiftadd_fir3.sv
module shiftadd_fir3 #(
   parameter int IN_W  = 8,
   parameter int FORM  = 0,
   localparam int OUT_W = fir_sa_pkg::out_width(IN_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_data
);
   import fir_sa_pkg::*;

   localparam int HIST = 2;

   if (IN_W < 2) begin : g_bad_width
      $error("shiftadd_fir3: IN_W must be at least 2");
   end
   if (FORM != FORM_SHARED && FORM != FORM_PRESUM) begin : g_bad_form
      $error("shiftadd_fir3: FORM must be 0 or 1");
   end

   logic [HIST-1:0][IN_W-1:0] hist;
   logic signed [OUT_W-1:0]   sum;

   fir_tap_line #(.W(IN_W), .DEPTH(HIST)) u_taps (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (in_valid),
      .din   (in_data),
      .taps  (hist)
   );

   if (FORM == FORM_SHARED) begin : g_shared
      fir_form_shared #(.IN_W(IN_W), .OW(OUT_W)) u_form (
         .x0 (in_data),
         .x1 ($signed(hist[0])),
         .x2 ($signed(hist[1])),
         .y  (sum)
      );
   end else begin : g_presum
      fir_form_presum #(.IN_W(IN_W), .OW(OUT_W)) u_form (
         .x0 (in_data),
         .x1 ($signed(hist[0])),
         .x2 ($signed(hist[1])),
         .y  (sum)
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= sum;
      end
   end

   // R2: a result follows every accepted sample after one cycle
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2: no result without a sample in the previous cycle
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R5: output word holds across idle cycles
   a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   // R1: reset clears the output
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (out_valid == 1'b0 && out_data == '0));
endmodule

// File: tb/tb_shiftadd_fir3.sv
`timescale 1ns/1ps
module tb_shiftadd_fir3;
   localparam int IN_W  = 8;
   localparam int OUT_W = IN_W + 5;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    in_valid;
   logic signed [IN_W-1:0]  in_data;
   logic                    ov_a, ov_b;
   logic signed [OUT_W-1:0] od_a, od_b;

   int n_vec  = 0;
   int n_fail = 0;
   int h1 = 0, h2 = 0;   // model history
   int last_out = 0;
   bit finished = 0;

   always #4 clk = ~clk;  // 125 MHz

   shiftadd_fir3 #(.IN_W(IN_W), .FORM(0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(ov_a), .out_data(od_a));

   shiftadd_fir3 #(.IN_W(IN_W), .FORM(1)) dut_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(ov_b), .out_data(od_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Push one sample, then check both variants one edge later.
   task automatic push(input int x, input string req);
      int expv;
      in_valid = 1'b1;
      in_data  = IN_W'(x);
      expv = 5*x + 13*h1 + 5*h2;
      @(negedge clk);
      in_valid = 1'b0;
      h2 = h1; h1 = x; last_out = expv;
      chk(ov_a == 1'b1, {req, " R2 valid form0"}, int'(ov_a), 1);
      chk(ov_b == 1'b1, {req, " R2 valid form1"}, int'(ov_b), 1);
      chk(int'(od_a) == expv, {req, " R3 form0"}, int'(od_a), expv);
      chk(int'(od_b) == expv, {req, " R3 form1"}, int'(od_b), expv);
      chk(od_a == od_b, {req, " R7 forms agree"}, int'(od_b), int'(od_a));
   endtask

   // Idle cycles with garbage on in_data.
   task automatic idle(input int cycles, input string req);
      for (int i = 0; i < cycles; i++) begin
         in_valid = 1'b0;
         in_data  = IN_W'($urandom);
         @(negedge clk);
         chk(ov_a == 1'b0 && ov_b == 1'b0, {req, " R2 no valid"}, int'(ov_a | ov_b), 0);
         chk(int'(od_a) == last_out && int'(od_b) == last_out, {req, " R5 hold"},
             int'(od_a), last_out);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      chk(ov_a == 0 && ov_b == 0, "R1 valid in reset", int'(ov_a | ov_b), 0);
      chk(od_a == 0 && od_b == 0, "R1 data in reset", int'(od_a), 0);
      rst_n = 1'b1;
      h1 = 0; h2 = 0; last_out = 0;
      @(negedge clk);
      chk(ov_a == 0 && od_a == 0, "R1 after release", int'(od_a), 0);
   endtask

   task automatic t_impulse();
      push(1, "R1 first out 5x");
      push(0, "R3 impulse");
      push(0, "R3 impulse");
      push(0, "R3 impulse");
   endtask

   task automatic t_gaps();
      push(3, "R4");
      idle(3, "R4");
      push(-2, "R4");
      idle(1, "R4");
      push(7, "R4 history kept across gaps");
      push(-9, "R4");
   endtask

   task automatic t_extremes();
      push(-128, "R6"); push(-128, "R6"); push(-128, "R6 min");
      chk(int'(od_a) == -2944, "R6 all -128", int'(od_a), -2944);
      push(127, "R6"); push(127, "R6"); push(127, "R6 max");
      chk(int'(od_a) == 2921, "R6 all 127", int'(od_a), 2921);
      push(-128, "R6 mixed"); push(127, "R6 mixed"); push(-128, "R6 mixed");
   endtask

   task automatic t_random();
      for (int i = 0; i < 300; i++) begin
         int v;
         v = int'($signed(IN_W'($urandom)));
         push(v, "R3 R7 random");
         if (($urandom % 4) == 0) idle(1 + ($urandom % 3), "R4 random gap");
      end
   endtask

   task automatic t_mid_reset();
      push(50, "R3");
      push(-60, "R3");
      t_reset();
      push(11, "R1 history cleared");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_impulse();
      t_gaps();
      t_extremes();
      t_random();
      t_mid_reset();
      idle(2, "R5 tail");
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         n_vec++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule